// File: doc/BRIEF.md
# SAR ADC conversion and readout sequencer

This block sits between a system clock domain and a successive-approximation ADC that starts a conversion on the rising edge of a convert line and returns its result over a serial data pin. One start pulse makes the block run a complete timed pass: an optional low quiet interval, a conversion wait in which the converter must not be disturbed, and then a serial read of a single result word. The word is delivered as a parallel value with a one-cycle valid strobe.

Two wirings are supported, selected per conversion by an input. In the three-wire wiring, the chip-select output doubles as the convert line. It drops for the quiet interval, rises to start the conversion, stays high through the conversion wait, and drops again for the read. In the four-wire wiring, a separate convert output is raised at the start and held until the read completes, while chip-select stays high through the conversion wait and drops only for the read.

Result width, signedness and the converter's timing class are parameters. The normal or fast (turbo) conversion time is chosen per conversion by an input. All nanosecond figures become clock-cycle counts by rounding up.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, cs_n_o is 1, and cnv_o, sclk_o, busy_o, valid_o and overrun_o are all 0.
- R2: In three-wire mode (four_wire_i=0 at start), cs_n_o goes low for ceil(QUIET_NS/CLK_NS) cycles immediately after the start is accepted, then rises to begin the conversion.
- R3: The conversion wait, with cs_n_o held high, lasts ceil(T/CLK_NS) cycles. T is set by the timing class and by turbo_i sampled at start: for SLOW_CLASS=0 it is 420 ns normal and 320 ns turbo, and for SLOW_CLASS=1 it is 500 ns normal and 400 ns turbo.
- R4: sclk_o is never high while cs_n_o is high, so there is no serial clocking during a conversion wait or while idle.
- R5: The read clocks exactly RES_W bits, MSB first, sampling sdo_i as sclk_o rises. sclk_o idles low and each phase lasts SCLK_HALF cycles. As a result, busy_o stays high for quiet + conversion + 2*RES_W*SCLK_HALF cycles.
- R6: In four-wire mode, cnv_o is high in every cycle in which busy_o is high and is low again when valid_o pulses. In three-wire mode, cnv_o stays low.
- R7: data_o is 32 bits wide when RES_W > 16, otherwise 16 bits. With DIFF=0, the result is zero-extended into the upper bits.
- R8: With DIFF=1, the result is treated as two's complement and sign-extended from bit RES_W-1.
- R9: valid_o is a single-cycle pulse that occurs in the first cycle busy_o is low after a conversion, and data_o holds the new word in that cycle.
- R10: A start_i while busy_o is high is ignored: it neither produces a result nor lengthens the pass. It sets overrun_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled each clock |
| four_wire_i | input | 1 | 1 selects the separate convert line, sampled at start |
| turbo_i | input | 1 | 1 selects the fast conversion time, sampled at start |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select (three-wire: also the convert line) |
| cnv_o | output | 1 | Separate convert line for the four-wire wiring |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | High from an accepted start until the result is valid |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | RES_W>16 ? 32 : 16 | Result word, sign- or zero-extended |
| overrun_o | output | 1 | Sticky flag for starts seen while busy |

## Verification
A wrong phase counter shows up as a busy window that is too short or too long. The bench measures every window against the cycle budget rebuilt from the nanosecond figures, so a miscount is caught at the result strobe of the pass in which it occurs. A shift or bit-count error shows up as a wrong or wrongly extended word at that same strobe. A mis-sequenced chip-select or convert line shows up in the first cycle that clocks during a conversion or drops the convert line early. Two instances cover both timing classes, both widths and both signedness settings. They run identical command streams through a scoreboard, which also catches results that should have been swallowed by an overrun.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUIET = 2'd1,
        ST_CONV  = 2'd2,
        ST_READ  = 2'd3
    } seq_state_e;

    // Delay in clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          sclk;
    } gen_regs_t;

    gen_regs_t gen_d, gen_q;
    logic      expire;

    always_comb begin
        gen_d  = gen_q;
        expire = (gen_q.cnt == '0);
        rise_o = run_i && expire && !gen_q.sclk;
        fall_o = run_i && expire && gen_q.sclk;
        if (!run_i) begin
            gen_d.cnt  = HW'(HALF - 1);
            gen_d.sclk = 1'b0;
        end else if (expire) begin
            gen_d.cnt  = HW'(HALF - 1);
            gen_d.sclk = ~gen_q.sclk;
        end else begin
            gen_d.cnt = gen_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.cnt  <= HW'(HALF - 1);
            gen_q.sclk <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sclk_o = gen_q.sclk;

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int RES_W = 18,
    parameter int OUT_W = 32,
    parameter bit DIFF  = 1'b1
) (
    input  logic [RES_W-1:0] raw_i,
    output logic [OUT_W-1:0] word_o
);

    generate
        if (DIFF) begin : g_signed
            assign word_o = OUT_W'($signed(raw_i));
        end else begin : g_unsigned
            assign word_o = OUT_W'(raw_i);
        end
    endgenerate

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 18,
    parameter bit DIFF       = 1'b1,
    parameter bit SLOW_CLASS = 1'b1,
    parameter int CLK_NS     = 20,
    parameter int QUIET_NS   = 20,
    parameter int SCLK_HALF  = 2,
    localparam int OUT_W     = (RES_W > 16) ? 32 : 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             four_wire_i,
    input  logic             turbo_i,
    input  logic             sdo_i,
    output logic             cs_n_o,
    output logic             cnv_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] data_o,
    output logic             overrun_o
);

    localparam int NORM_NS    = SLOW_CLASS ? 500 : 420;
    localparam int FAST_NS    = SLOW_CLASS ? 400 : 320;
    localparam int QUIET_CYC  = ns_to_cycles(QUIET_NS, CLK_NS);
    localparam int NORM_CYC   = ns_to_cycles(NORM_NS, CLK_NS);
    localparam int FAST_CYC   = ns_to_cycles(FAST_NS, CLK_NS);
    localparam int CNT_MAX    = max_of(QUIET_CYC, max_of(NORM_CYC, FAST_CYC));
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int BIT_W      = $clog2(RES_W + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        logic [RES_W-1:0] shreg;
        logic             turbo;
        logic             cs_n;
        logic             cnv;
        logic             busy;
        logic             valid;
        logic [OUT_W-1:0] data;
        logic             ovr;
    } seq_regs_t;

    seq_regs_t        seq_d, seq_q;
    logic             run_read;
    logic             bit_rise;
    logic             bit_fall;
    logic [OUT_W-1:0] fmt_word;

    assign run_read = (seq_q.st == ST_READ);

    sar_sclk_gen #(
        .HALF (SCLK_HALF)
    ) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_read),
        .sclk_o (sclk_o),
        .rise_o (bit_rise),
        .fall_o (bit_fall)
    );

    sar_result_fmt #(
        .RES_W (RES_W),
        .OUT_W (OUT_W),
        .DIFF  (DIFF)
    ) u_fmt (
        .raw_i  (seq_q.shreg),
        .word_o (fmt_word)
    );

    function automatic logic [CNT_W-1:0] conv_load(input logic fast);
        return fast ? CNT_W'(FAST_CYC - 1) : CNT_W'(NORM_CYC - 1);
    endfunction

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.busy  = 1'b1;
                    seq_d.turbo = turbo_i;
                    seq_d.bits  = '0;
                    if (four_wire_i) begin
                        seq_d.st   = ST_CONV;
                        seq_d.cnv  = 1'b1;
                        seq_d.cs_n = 1'b1;
                        seq_d.cnt  = conv_load(turbo_i);
                    end else begin
                        seq_d.st   = ST_QUIET;
                        seq_d.cs_n = 1'b0;
                        seq_d.cnt  = CNT_W'(QUIET_CYC - 1);
                    end
                end
            end
            ST_QUIET: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_CONV;
                    seq_d.cs_n = 1'b1;
                    seq_d.cnt  = conv_load(seq_q.turbo);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_CONV: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_READ;
                    seq_d.cs_n = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_READ: begin
                if (bit_rise) begin
                    seq_d.shreg = {seq_q.shreg[RES_W-2:0], sdo_i};
                    seq_d.bits  = seq_q.bits + 1'b1;
                end
                if (bit_fall && (seq_q.bits == BIT_W'(RES_W))) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.cs_n  = 1'b1;
                    seq_d.cnv   = 1'b0;
                    seq_d.busy  = 1'b0;
                    seq_d.valid = 1'b1;
                    seq_d.data  = fmt_word;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (start_i && (seq_q.st != ST_IDLE)) begin
            seq_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o    = seq_q.cs_n;
    assign cnv_o     = seq_q.cnv;
    assign busy_o    = seq_q.busy;
    assign valid_o   = seq_q.valid;
    assign data_o    = seq_q.data;
    assign overrun_o = seq_q.ovr;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cs_n_o,
    input logic cnv_o,
    input logic sclk_o,
    input logic busy_o,
    input logic valid_o,
    input logic overrun_o
);

    // R4
    quiet_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R6
    cnv_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> busy_o);

    // R9
    valid_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> overrun_o);

    // R2
    idle_start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

bind sar_conv_seq sar_conv_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cs_n_o    (cs_n_o),
    .cnv_o     (cnv_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o)
);

// File: tb/sar_conv_seq_bench.sv
module sar_sdo_model #(
    parameter int W = 18
) (
    input  logic         cs_n,
    input  logic         sclk,
    input  logic [W-1:0] word,
    output logic         sdo
);
    int idx = 0;

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) idx <= 0;
        else      idx <= idx + 1;
    end

    assign sdo = (idx < W) ? word[W-1-idx] : 1'b0;
endmodule

module sar_conv_seq_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic four  = 1'b0;
    logic turbo = 1'b0;

    logic [17:0] word_a = '0;
    logic [13:0] word_b = '0;

    logic        sdo_a, cs_a, cnv_a, sclk_a, busy_a, valid_a, ovr_a;
    logic [31:0] data_a;
    logic        sdo_b, cs_b, cnv_b, sclk_b, busy_b, valid_b, ovr_b;
    logic [15:0] data_b;

    sar_conv_seq #(.RES_W(18), .DIFF(1'b1), .SLOW_CLASS(1'b1)) u_sar_conv_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .four_wire_i(four),
        .turbo_i(turbo), .sdo_i(sdo_a), .cs_n_o(cs_a), .cnv_o(cnv_a),
        .sclk_o(sclk_a), .busy_o(busy_a), .valid_o(valid_a),
        .data_o(data_a), .overrun_o(ovr_a));

    sar_conv_seq #(.RES_W(14), .DIFF(1'b0), .SLOW_CLASS(1'b0)) u_sar_conv_seq_w14 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .four_wire_i(four),
        .turbo_i(turbo), .sdo_i(sdo_b), .cs_n_o(cs_b), .cnv_o(cnv_b),
        .sclk_o(sclk_b), .busy_o(busy_b), .valid_o(valid_b),
        .data_o(data_b), .overrun_o(ovr_b));

    sar_sdo_model #(.W(18)) u_model_a (.cs_n(cs_a), .sclk(sclk_a), .word(word_a), .sdo(sdo_a));
    sar_sdo_model #(.W(14)) u_model_b (.cs_n(cs_b), .sclk(sclk_b), .word(word_b), .sdo(sdo_b));

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_a[$];
    logic [15:0] exp_b[$];
    int          len_a[$];
    int          len_b[$];

    int cnt_a = 0, cnt_b = 0;
    int sclk_viol = 0, cnv_viol = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cyc(input int ns);
        return (ns + 19) / 20;
    endfunction

    function automatic int busy_len(input bit fw, input bit tb, input int w, input bit slow);
        int conv_ns;
        conv_ns = slow ? (tb ? 400 : 500) : (tb ? 320 : 420);
        return (fw ? 0 : cyc(20)) + cyc(conv_ns) + 2 * w * 2;
    endfunction

    // Driver: pushes expected results, pulses start, optionally a second start while busy
    task automatic run_conv(input bit fw, input bit tb, input logic [17:0] va,
                            input logic [13:0] vb, input bit extra);
        word_a = va;
        word_b = vb;
        four   = fw;
        turbo  = tb;
        exp_a.push_back({{14{va[17]}}, va});
        exp_b.push_back({2'b00, vb});
        len_a.push_back(busy_len(fw, tb, 18, 1'b1));
        len_b.push_back(busy_len(fw, tb, 14, 1'b0));
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (extra) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        do @(negedge clk); while (busy_a || busy_b);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare results and busy window lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_a && sclk_a) sclk_viol++;
            if (cs_b && sclk_b) sclk_viol++;
            if (busy_a && (cnv_a != four)) cnv_viol++;
            if (busy_b && (cnv_b != four)) cnv_viol++;
            if (!busy_a && cnv_a) cnv_viol++;
            if (!busy_b && cnv_b) cnv_viol++;
            if (busy_a) cnt_a++;
            if (busy_b) cnt_b++;
            if (valid_a) begin
                if (exp_a.size() == 0) begin
                    check(1'b0, "R10 unexpected result 18b", data_a, 0);
                end else begin
                    logic [31:0] e;
                    int l;
                    e = exp_a.pop_front();
                    l = len_a.pop_front();
                    check(data_a == e, "R5 R8 data 18b", data_a, e);
                    check(cnt_a == l, "R2 R3 R5 busy window 18b", cnt_a, l);
                    check(!busy_a && !cnv_a, "R9 R6 strobe state 18b", {busy_a, cnv_a}, 0);
                end
                cnt_a = 0;
            end
            if (valid_b) begin
                if (exp_b.size() == 0) begin
                    check(1'b0, "R10 unexpected result 14b", data_b, 0);
                end else begin
                    logic [15:0] e;
                    int l;
                    e = exp_b.pop_front();
                    l = len_b.pop_front();
                    check(data_b == e, "R5 R7 data 14b", data_b, e);
                    check(cnt_b == l, "R2 R3 R5 busy window 14b", cnt_b, l);
                    check(!busy_b && !cnv_b, "R9 R6 strobe state 14b", {busy_b, cnv_b}, 0);
                end
                cnt_b = 0;
            end
        end
    end

    bit finished = 1'b0;

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_a && !cnv_a && !sclk_a && !busy_a && !valid_a && !ovr_a,
              "R1 reset state 18b", {cs_a, cnv_a, sclk_a, busy_a, valid_a, ovr_a}, 6'b100000);
        check(cs_b && !cnv_b && !sclk_b && !busy_b && !valid_b && !ovr_b,
              "R1 reset state 14b", {cs_b, cnv_b, sclk_b, busy_b, valid_b, ovr_b}, 6'b100000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_a && !busy_a && !ovr_a, "R1 after release", {cs_a, busy_a, ovr_a}, 3'b100);

        // R2 R3 three-wire normal, negative signed value (R8)
        run_conv(1'b0, 1'b0, 18'h20001, 14'h2A5B, 1'b0);
        // R3 three-wire turbo, largest positive / full-scale unsigned (R7)
        run_conv(1'b0, 1'b1, 18'h1FFFF, 14'h3FFF, 1'b0);
        // R6 four-wire normal, zeros
        run_conv(1'b1, 1'b0, 18'h00000, 14'h0000, 1'b0);
        // R6 four-wire turbo, minus one
        run_conv(1'b1, 1'b1, 18'h3FFFF, 14'h1555, 1'b0);
        check(!ovr_a && !ovr_b, "R10 no overrun yet", {ovr_a, ovr_b}, 0);

        // R10 start while busy is ignored and flagged
        run_conv(1'b0, 1'b0, 18'h15A5A, 14'h0F0F, 1'b1);
        check(ovr_a && ovr_b, "R10 overrun set", {ovr_a, ovr_b}, 2'b11);
        run_conv(1'b1, 1'b0, 18'h2C3D1, 14'h2001, 1'b0);
        check(ovr_a && ovr_b, "R10 overrun sticky", {ovr_a, ovr_b}, 2'b11);

        check(exp_a.size() == 0 && exp_b.size() == 0, "R10 all results seen, none extra",
              exp_a.size() + exp_b.size(), 0);
        check(sclk_viol == 0, "R4 no sclk while cs high", sclk_viol, 0);
        check(cnv_viol == 0, "R6 cnv follows wiring", cnv_viol, 0);

        finished = 1'b1;
        summary();
    end

endmodule